// File: doc/BRIEF.md
# Escape-Prefixed Coprocessor Opcode Decoder

This block watches a byte stream and picks out two-byte instructions that belong to a numeric coprocessor. Such an instruction is marked by a fixed five-bit escape prefix in the upper bits of its first byte. The 6-bit coprocessor opcode is split between the two bytes, with the addressing-mode fields between its two halves. The block joins the two opcode halves and extracts the mode and register/memory fields. It also reports whether a memory operand is involved and how many displacement bytes follow.

Each decode result is registered and announced by a one-cycle strobe. A first byte without the escape prefix is rejected at once. The rejection also produces a strobe, with the coprocessor flag low and every field at zero. The block then consumes the displacement bytes that follow a decoded instruction. Those bytes are never taken for the start of a new instruction.

Opcode execution and effective-address calculation belong to later stages.

Top module: `esc_opcode_decoder`

## Requirements
- R1: A byte taken while the block expects a first byte counts as an escape when bits [7:3] equal 11011. The block then takes the next accepted byte as the second byte, and only that second byte produces a strobe, with out_cop high.
- R2: For an escape pair, out_opcode equals {first[2:0], second[5:3]}.
- R3: For an escape pair, out_mode equals second[7:6] and out_rm equals second[2:0].
- R4: When out_mode is 11 (register operands), out_mem is 0 and out_disp is 0.
- R5: For modes 00, 01 and 10, out_mem is 1. out_disp is 1 for mode 01 and 2 for mode 10. For mode 00 it is 2 when rm is 110 and 0 otherwise.
- R6: A non-escape first byte produces a strobe with out_cop at 0 and opcode, mode, rm, mem and disp all at 0.
- R7: out_valid is high for exactly the one cycle after the clock edge at which the byte that completes a result is accepted. Cycles with in_valid low consume no byte.
- R8: After an escape pair, the next out_disp accepted bytes are consumed without any strobe, whatever their value. The byte after them is treated as a first byte again.
- R9: Between strobes, all result outputs keep their last values.
- R10: After reset, all outputs are 0 and the block expects a first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A byte is presented on in_byte this cycle |
| in_byte | input | 8 | Stream byte |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_cop | output | 1 | Result is a coprocessor instruction |
| out_opcode | output | 6 | Joined coprocessor opcode |
| out_mode | output | 2 | Addressing-mode field |
| out_rm | output | 3 | Register/memory field |
| out_mem | output | 1 | Instruction uses a memory operand |
| out_disp | output | 2 | Number of displacement bytes that follow |

## Verification
Every result appears one clock after the edge that accepts its completing byte. That byte is the second byte for an escape pair and the first byte for a rejection. Inputs are driven on the falling edge and outputs are compared on the following falling edge, one cycle later, so each comparison sees exactly one rising edge. The reference model is updated in that same step, so strobes, held fields and skipped displacement bytes are compared on every clock, including idle gaps.

// File: rtl/esc_dec_pkg.sv
package esc_dec_pkg;
  localparam int BYTE_W = 8;
  localparam int ESC_W  = 5;
  localparam logic [ESC_W-1:0] ESC_PAT = 5'b11011;
  localparam int HALF_W = 3;
  localparam int OP_W   = 2 * HALF_W;
  localparam int MODE_W = 2;
  localparam int RM_W   = 3;
  localparam int DISP_W = 2;

  localparam logic [MODE_W-1:0] MODE_REG   = 2'b11;
  localparam logic [MODE_W-1:0] MODE_D8    = 2'b01;
  localparam logic [MODE_W-1:0] MODE_D16   = 2'b10;
  localparam logic [RM_W-1:0]   RM_DIRECT  = 3'b110;

  typedef struct packed {
    logic              cop;
    logic [OP_W-1:0]   opcode;
    logic [MODE_W-1:0] mode;
    logic [RM_W-1:0]   rm;
    logic              mem;
    logic [DISP_W-1:0] disp;
  } dec_t;

  function automatic logic is_escape(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1 -: ESC_W] == ESC_PAT;
  endfunction

  function automatic logic [DISP_W-1:0] disp_bytes(input logic [MODE_W-1:0] mode,
                                                   input logic [RM_W-1:0]   rm);
    logic [DISP_W-1:0] n;
    unique case (mode)
      MODE_D8:  n = 2'd1;
      MODE_D16: n = 2'd2;
      MODE_REG: n = 2'd0;
      default:  n = (rm == RM_DIRECT) ? 2'd2 : 2'd0;
    endcase
    return n;
  endfunction

  function automatic dec_t decode_pair(input logic [HALF_W-1:0] hi_op,
                                       input logic [BYTE_W-1:0] second);
    dec_t d;
    d.cop    = 1'b1;
    d.mode   = second[BYTE_W-1 -: MODE_W];
    d.opcode = {hi_op, second[RM_W +: HALF_W]};
    d.rm     = second[RM_W-1:0];
    d.mem    = (d.mode != MODE_REG);
    d.disp   = disp_bytes(d.mode, d.rm);
    return d;
  endfunction
endpackage

// File: rtl/esc_byte_sequencer.sv
module esc_byte_sequencer
  import esc_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic [DISP_W-1:0] disp_req,
  output logic              take_first,
  output logic              take_second,
  output logic              skip_byte,
  output logic              esc_hit,
  output logic [HALF_W-1:0] held_hi
);
  typedef enum logic [1:0] {S_FIRST, S_SECOND, S_SKIP} seq_e;
  seq_e              st;
  logic [DISP_W-1:0] left;

  assign take_first  = in_valid && (st == S_FIRST);
  assign take_second = in_valid && (st == S_SECOND);
  assign skip_byte   = in_valid && (st == S_SKIP);
  assign esc_hit     = take_first && is_escape(in_byte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_FIRST;
      left    <= '0;
      held_hi <= '0;
    end else begin
      if (esc_hit) begin
        st      <= S_SECOND;
        held_hi <= in_byte[HALF_W-1:0];
      end else if (take_second) begin
        left <= disp_req;
        st   <= (disp_req != '0) ? S_SKIP : S_FIRST;
      end else if (skip_byte) begin
        left <= left - 1'b1;
        if (left == DISP_W'(1)) st <= S_FIRST;
      end
    end
  end
endmodule

// File: rtl/esc_field_decoder.sv
module esc_field_decoder
  import esc_dec_pkg::*;
(
  input  logic [HALF_W-1:0] hi_op,
  input  logic [BYTE_W-1:0] second,
  output dec_t              dec
);
  always_comb dec = decode_pair(hi_op, second);
endmodule

// File: rtl/esc_opcode_decoder.sv
module esc_opcode_decoder
  import esc_dec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       out_valid,
  output logic       out_cop,
  output logic [5:0] out_opcode,
  output logic [1:0] out_mode,
  output logic [2:0] out_rm,
  output logic       out_mem,
  output logic [1:0] out_disp
);
  logic              take_first, take_second, skip_byte, esc_hit;
  logic [HALF_W-1:0] held_hi;
  dec_t              pair_dec, res;
  logic              reject;

  esc_byte_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .disp_req(pair_dec.disp), .take_first(take_first), .take_second(take_second),
    .skip_byte(skip_byte), .esc_hit(esc_hit), .held_hi(held_hi)
  );

  esc_field_decoder u_dec (.hi_op(held_hi), .second(in_byte), .dec(pair_dec));

  assign reject = take_first && !esc_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res       <= '0;
    end else begin
      out_valid <= take_second || reject;
      if (take_second) res <= pair_dec;
      else if (reject) res <= '0;
    end
  end

  assign out_cop    = res.cop;
  assign out_opcode = res.opcode;
  assign out_mode   = res.mode;
  assign out_rm     = res.rm;
  assign out_mem    = res.mem;
  assign out_disp   = res.disp;
endmodule

// File: rtl/esc_opcode_decoder_chk.sv
module esc_opcode_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       out_valid,
  input logic       out_cop,
  input logic [5:0] out_opcode,
  input logic [1:0] out_mode,
  input logic [2:0] out_rm,
  input logic       out_mem,
  input logic [1:0] out_disp,
  input logic       take_first,
  input logic       take_second,
  input logic       skip_byte
);
  // R7: a strobe follows an accepted byte
  a_r7_strobe_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));
  // R8: a skipped byte yields no strobe
  a_r8_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
    skip_byte |=> !out_valid);
  // R1: at most one byte role per cycle
  a_r1_one_role: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take_first, take_second, skip_byte}));
  // R6: a rejection carries all-zero fields
  a_r6_reject_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_cop) |-> (out_opcode == 6'd0 && out_mode == 2'd0 &&
                                 out_rm == 3'd0 && !out_mem && out_disp == 2'd0));
  // R4: register mode touches no memory
  a_r4_reg_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_cop && out_mode == 2'b11) |-> (!out_mem && out_disp == 2'd0));
  // R5: memory modes flag a memory operand
  a_r5_mem_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_cop && out_mode != 2'b11) |-> (out_mem && out_disp != 2'd3));
  // R9: fields hold between strobes
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_cop) && $stable(out_opcode) && $stable(out_mode) &&
                    $stable(out_rm) && $stable(out_mem) && $stable(out_disp)));
endmodule

bind esc_opcode_decoder esc_opcode_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_cop(out_cop), .out_opcode(out_opcode), .out_mode(out_mode), .out_rm(out_rm),
  .out_mem(out_mem), .out_disp(out_disp), .take_first(take_first),
  .take_second(take_second), .skip_byte(skip_byte)
);

// File: tb/esc_opcode_decoder_bench.sv
module esc_opcode_decoder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       out_valid, out_cop, out_mem;
  logic [5:0] out_opcode;
  logic [1:0] out_mode, out_disp;
  logic [2:0] out_rm;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model state
  int m_state = 0;   // 0 expect first, 1 expect second, 2 skipping
  int m_left = 0;
  int m_first = 0;
  int e_valid = 0, e_cop = 0, e_op = 0, e_mode = 0, e_rm = 0, e_mem = 0, e_disp = 0;

  always #5 clk = ~clk;

  esc_opcode_decoder u_esc_opcode_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .out_valid(out_valid), .out_cop(out_cop), .out_opcode(out_opcode),
    .out_mode(out_mode), .out_rm(out_rm), .out_mem(out_mem), .out_disp(out_disp)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model(input bit v, input int b);
    e_valid = 0;
    if (!v) return;
    if (m_state == 0) begin
      if ((b / 8) == 27) begin
        m_state = 1;
        m_first = b;
      end else begin
        e_valid = 1; e_cop = 0; e_op = 0; e_mode = 0; e_rm = 0; e_mem = 0; e_disp = 0;
      end
    end else if (m_state == 1) begin
      e_valid = 1;
      e_cop   = 1;
      e_mode  = b / 64;
      e_rm    = b % 8;
      e_op    = (m_first % 8) * 8 + (b / 8) % 8;
      e_mem   = (e_mode == 3) ? 0 : 1;
      if (e_mode == 1) e_disp = 1;
      else if (e_mode == 2) e_disp = 2;
      else if (e_mode == 0 && e_rm == 6) e_disp = 2;
      else e_disp = 0;
      m_left  = e_disp;
      m_state = (e_disp > 0) ? 2 : 0;
    end else begin
      m_left--;
      if (m_left == 0) m_state = 0;
    end
  endtask

  task automatic step(input bit v, input int b);
    bit skipping;
    string ft;
    skipping = (m_state == 2) && v;
    in_valid = v;
    in_byte  = 8'(b);
    model(v, b);
    @(negedge clk);
    check(skipping ? "R8 strobe" : "R7 strobe", int'(out_valid), e_valid);
    check("R1 cop", int'(out_cop), e_cop);
    ft = !e_valid ? "R9" : (!e_cop ? "R6" : "R2");
    check({ft, " opcode"}, int'(out_opcode), e_op);
    ft = !e_valid ? "R9" : (!e_cop ? "R6" : "R3");
    check({ft, " mode"}, int'(out_mode), e_mode);
    check({ft, " rm"}, int'(out_rm), e_rm);
    ft = !e_valid ? "R9" : (!e_cop ? "R6" : (e_mode == 3 ? "R4" : "R5"));
    check({ft, " mem"}, int'(out_mem), e_mem);
    check({ft, " disp"}, int'(out_disp), e_disp);
  endtask

  initial begin
    #200000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R10: reset state
    check("R10 valid", int'(out_valid), 0);
    check("R10 cop", int'(out_cop), 0);
    check("R10 fields", int'({out_opcode, out_mode, out_rm, out_mem, out_disp}), 0);
    rst_n = 1'b1;
    step(0, 0);
    // R6: non-escape bytes, back to back
    step(1, 8'h12);
    step(1, 8'hD7);
    step(1, 8'hFF);
    // R4: register mode pair
    step(1, 8'hD9); step(1, 8'hC1);
    // R7: gap between the two bytes
    step(1, 8'hDF); step(0, 8'h55); step(0, 8'h00); step(1, 8'hFA);
    step(0, 0);
    // R5/R8: mode 01, one displacement byte that looks like an escape
    step(1, 8'hD8); step(1, 8'h45); step(1, 8'hDF); step(1, 8'h33);
    // mode 10, two displacement bytes with a gap
    step(1, 8'hDD); step(1, 8'h86); step(1, 8'hD9); step(0, 8'hD9); step(1, 8'hC0);
    // mode 00 direct address
    step(1, 8'hDE); step(1, 8'h06); step(1, 8'h11); step(1, 8'h22);
    // mode 00 no displacement, all opcode bits set
    step(1, 8'hDF); step(1, 8'h3B); step(1, 8'h01);
    // sweep of second bytes
    for (int i = 0; i < 256; i += 7) begin
      step(1, 8'hD8 + (i % 8));
      step(1, i);
      for (int k = 0; k < 3; k++) step(((i + k) % 2) == 0, 8'hDB);
      step(1, 8'h40);
      step(1, 8'h40);
      step(1, 8'h40);
    end
    step(0, 0);
    step(0, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule